// File: doc/BRIEF.md
# Layer-1 Activation Handshake Controller

This block sequences bring-up and tear-down of a four-wire subscriber line at layer 1. One input picks the end it plays: the network end or the terminal end. From the framer it takes a sync flag, a two-bit class for the received signal and the received activation bit. It also takes local requests to activate and to deactivate. From these it decides which line signal (Info0 to Info4) to transmit. It also drives the activation bit sent in outgoing frames, an enable for the B1/B2/D payload and an active flag.

Activation can start from either end. The terminal can wake an idle network end with an unframed signal. The network end can also start on its own by sending zero-payload frames at once, which leaves out the terminal's wake-up exchange. Either end tears the link down by going idle. The peer sees this as loss of sync followed by a run of idle frames. Line coding, framing and clock recovery are handled elsewhere.

Top module: `l1_activation_ctrl`

## Requirements
- R1: After reset the block transmits class 0 (idle), with the activation bit, payload enable and active flag all low.
- R2: Network end: from the deactivated state, a local activate request or a received class of 1 (unframed wake) makes the next cycle transmit class 2 with activation bit 0 and payload disabled. Received classes 0, 2 and 3 leave it idle.
- R3: Terminal end: from the deactivated state with no received sync, a local activate request makes the next cycle transmit class 1 (unframed wake).
- R4: Terminal end: received sync while deactivated or waking makes the next cycle transmit class 3 with payload enabled. This is how network-initiated activation enters.
- R5: Network end: while sending class 2, received sync together with received class 3 (framed data) makes the next cycle transmit class 4 with activation bit 1, payload enabled and the active flag set. Without both, the active flag stays low.
- R6: Terminal end: the active flag is set only after a cycle with sync and a received activation bit of 1. A received activation bit of 0 while active clears it on the next cycle.
- R7: Loss of received sync while active clears the active flag on the next cycle. The network end falls back to class 2 and the terminal end falls back to class 1.
- R8: A local deactivate request makes the next cycle transmit class 0 with the active flag and payload enable low, whatever the state.
- R9: In any state other than deactivated, IDLE_FRAMES consecutive frame ticks with received class 0 return the block to class 0 on the cycle after the last tick. A tick with any other class restarts the count.
- R10: The activation bit is only ever 1 while transmitting class 4. Payload enable is only ever 1 while transmitting class 3 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_nt | input | 1 | 1 = network end, 0 = terminal end; static outside reset |
| frame_tick | input | 1 | One-cycle pulse per line frame |
| rx_sync | input | 1 | Framer is locked to received frames |
| rx_class | input | 2 | Received signal: 0 idle, 1 unframed wake, 2 framed zero payload, 3 framed with data |
| rx_abit | input | 1 | Activation bit of the received frame |
| act_req | input | 1 | Local activate request |
| deact_req | input | 1 | Local deactivate request |
| tx_class | output | 3 | Signal to transmit, 0..4 for Info0..Info4 |
| tx_abit | output | 1 | Activation bit for outgoing frames |
| payload_en | output | 1 | Enable for B1/B2/D payload |
| active | output | 1 | Link is active |

## Verification
From reset, every received class is swept in both modes with no local request. This separates the one class that wakes the network end from the classes that must be ignored, and shows that the terminal end ignores the class without sync. Both entry paths are then driven through to the active state, so terminal-initiated and network-initiated bring-up are each shown to reach the right final signal. Idle runs of every length from one to IDLE_FRAMES are applied, along with a run broken by one non-idle frame, to pin down the exact timeout boundary. Loss of sync, a zero received activation bit and both local and remote deactivation are applied in each mode.

// File: rtl/l1_activation_ctrl.sv
module l1_activation_ctrl #(
  parameter int IDLE_FRAMES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_nt,
  input  logic       frame_tick,
  input  logic       rx_sync,
  input  logic [1:0] rx_class,
  input  logic       rx_abit,
  input  logic       act_req,
  input  logic       deact_req,
  output logic [2:0] tx_class,
  output logic       tx_abit,
  output logic       payload_en,
  output logic       active
);
  localparam int CW = $clog2(IDLE_FRAMES + 1);

  typedef enum logic [2:0] {S_DEACT, S_WAKE, S_AWAIT, S_SYNC, S_ACTIVE} st_t;
  st_t st, st_nx;
  logic [CW-1:0] idle_cnt;

  wire rx_idle  = (rx_class == 2'd0);
  wire rx_data  = rx_sync && (rx_class == 2'd3);
  wire idle_out = frame_tick && rx_idle && (st != S_DEACT) &&
                  (idle_cnt == CW'(IDLE_FRAMES - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                         idle_cnt <= '0;
    else if (st == S_DEACT || !rx_idle || idle_out)     idle_cnt <= '0;
    else if (frame_tick)                                idle_cnt <= idle_cnt + 1'b1;

  always_comb begin
    st_nx = st;
    if (deact_req || idle_out) st_nx = S_DEACT;
    else if (is_nt) begin
      case (st)
        S_DEACT:  if (act_req || rx_class == 2'd1) st_nx = S_AWAIT;
        S_AWAIT:  if (rx_data) st_nx = S_ACTIVE;
        S_ACTIVE: if (!rx_sync) st_nx = S_AWAIT;
        default:  st_nx = S_DEACT;
      endcase
    end else begin
      case (st)
        S_DEACT:  if (rx_sync) st_nx = S_SYNC; else if (act_req) st_nx = S_WAKE;
        S_WAKE:   if (rx_sync) st_nx = S_SYNC;
        S_SYNC:   if (!rx_sync) st_nx = S_WAKE; else if (rx_abit) st_nx = S_ACTIVE;
        S_ACTIVE: if (!rx_sync) st_nx = S_WAKE; else if (!rx_abit) st_nx = S_SYNC;
        default:  st_nx = S_DEACT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_DEACT;
    else        st <= st_nx;

  always_comb begin
    case (st)
      S_WAKE:   tx_class = 3'd1;
      S_AWAIT:  tx_class = 3'd2;
      S_SYNC:   tx_class = 3'd3;
      S_ACTIVE: tx_class = is_nt ? 3'd4 : 3'd3;
      default:  tx_class = 3'd0;
    endcase
  end

  assign active     = (st == S_ACTIVE);
  assign tx_abit    = active && is_nt;
  assign payload_en = active || (st == S_SYNC);
endmodule

module l1_activation_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       is_nt,
  input logic       rx_sync,
  input logic [1:0] rx_class,
  input logic       rx_abit,
  input logic       deact_req,
  input logic [2:0] tx_class,
  input logic       tx_abit,
  input logic       payload_en,
  input logic       active
);
  assert_deact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req |=> (tx_class == 3'd0 && !active && !payload_en));

  assert_los_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !rx_sync) |=> !active);

  assert_abit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abit |-> (tx_class == 3'd4));

  assert_payload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    payload_en |-> (tx_class >= 3'd3));

  assert_te_abit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_nt && !active && !rx_abit) |=> !active);

  assert_nt_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nt && !active && !(rx_sync && rx_class == 2'd3)) |=> !active);
endmodule

bind l1_activation_ctrl l1_activation_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .is_nt(is_nt), .rx_sync(rx_sync),
  .rx_class(rx_class), .rx_abit(rx_abit), .deact_req(deact_req),
  .tx_class(tx_class), .tx_abit(tx_abit), .payload_en(payload_en),
  .active(active)
);

// File: tb/sim_l1_activation_ctrl.sv
module sim_l1_activation_ctrl;
  localparam int N = 4;
  logic clk = 0, rst_n = 0, is_nt = 0, frame_tick = 0, rx_sync = 0, rx_abit = 0;
  logic act_req = 0, deact_req = 0;
  logic [1:0] rx_class = 0;
  logic [2:0] tx_class;
  logic tx_abit, payload_en, active;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  l1_activation_ctrl #(.IDLE_FRAMES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .is_nt(is_nt), .frame_tick(frame_tick),
    .rx_sync(rx_sync), .rx_class(rx_class), .rx_abit(rx_abit),
    .act_req(act_req), .deact_req(deact_req), .tx_class(tx_class),
    .tx_abit(tx_abit), .payload_en(payload_en), .active(active));

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(string r, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d exp %0d", r, got, exp);
    end
  endtask

  task automatic chk_out(string r, int cls, int ab, int pe, int ac);
    chk({r, " tx_class"}, tx_class, cls);
    chk({r, " tx_abit"}, tx_abit, ab);
    chk({r, " payload_en"}, payload_en, pe);
    chk({r, " active"}, active, ac);
  endtask

  task automatic do_reset(logic nt);
    rst_n = 0; is_nt = nt; frame_tick = 0; rx_sync = 0; rx_class = 0;
    rx_abit = 0; act_req = 0; deact_req = 0;
    cyc(); cyc(); rst_n = 1; cyc();
  endtask

  task automatic ticks(int k);
    for (int i = 0; i < k; i++) begin
      frame_tick = 1; cyc(); frame_tick = 0; cyc();
    end
  endtask

  task automatic nt_up();
    do_reset(1);
    act_req = 1; cyc(); act_req = 0;
    rx_sync = 1; rx_class = 3; cyc();
  endtask

  task automatic te_up();
    do_reset(0);
    rx_sync = 1; rx_class = 2; cyc();
    rx_abit = 1; rx_class = 3; cyc();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog got 0 exp 1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      chk_out("R1 reset", 0, 0, 0, 0);
    end

    // R2/R4: sweep received class from deactivated, no request
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++) begin
        do_reset(m[0]);
        rx_class = c[1:0]; cyc(); rx_class = 0;
        if (m == 1) chk_out("R2 rx sweep", (c == 1) ? 2 : 0, 0, 0, 0);
        else        chk_out("R4 no sync ignored", 0, 0, 0, 0);
      end

    // R2: NT local request
    do_reset(1); act_req = 1; cyc(); act_req = 0;
    chk_out("R2 nt act_req", 2, 0, 0, 0);
    rx_sync = 1; rx_class = 2; cyc();
    chk_out("R5 no data stays", 2, 0, 0, 0);
    rx_class = 3; cyc();
    chk_out("R5 nt active", 4, 1, 1, 1);

    // terminal-initiated path, terminal side
    do_reset(0); act_req = 1; cyc(); act_req = 0;
    chk_out("R3 te wake", 1, 0, 0, 0);
    rx_sync = 1; rx_class = 2; cyc();
    chk_out("R4 te sync", 3, 0, 1, 0);
    rx_abit = 1; rx_class = 3; cyc();
    chk_out("R6 te active", 3, 0, 1, 1);
    rx_abit = 0; cyc();
    chk_out("R6 abit drop", 3, 0, 1, 0);

    // network-initiated path, terminal side
    te_up();
    chk_out("R4 nt-init te active", 3, 0, 1, 1);

    // R7 loss of sync
    nt_up(); rx_sync = 0; rx_class = 2; cyc();
    chk_out("R7 nt los", 2, 0, 0, 0);
    te_up(); rx_sync = 0; cyc();
    chk_out("R7 te los", 1, 0, 0, 0);

    // R8 local deactivation on each side
    nt_up(); deact_req = 1; cyc(); deact_req = 0;
    chk_out("R8 nt deact", 0, 0, 0, 0);
    te_up(); deact_req = 1; cyc(); deact_req = 0;
    chk_out("R8 te deact", 0, 0, 0, 0);

    // R9 idle run length sweep in both modes
    for (int m = 0; m < 2; m++)
      for (int k = 1; k <= N; k++) begin
        do_reset(m[0]);
        act_req = 1; cyc(); act_req = 0;
        rx_class = 0; ticks(k);
        chk("R9 idle sweep", tx_class, (k == N) ? 0 : ((m == 1) ? 2 : 1));
      end

    // R9 broken run restarts count
    do_reset(1); act_req = 1; cyc(); act_req = 0;
    ticks(N - 1); rx_class = 2; ticks(1); rx_class = 0; ticks(N - 1);
    chk("R9 broken run", tx_class, 2);
    ticks(1);
    chk("R9 broken run final", tx_class, 0);

    // remote deactivation: peer goes idle while active
    te_up(); rx_sync = 0; rx_class = 0; rx_abit = 0; cyc();
    ticks(N);
    chk_out("R9 te remote deact", 0, 0, 0, 0);
    nt_up(); rx_sync = 0; rx_class = 0; cyc();
    ticks(N);
    chk_out("R9 nt remote deact", 0, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule